// File: doc/BRIEF.md
# Endpoint STALL Handshake Controller

This block sits beside the transaction engine of a USB device endpoint. It decides whether the endpoint answers a transaction with its normal ACK or NAK, or with a STALL. Firmware arms and disarms a force-stall state with single-cycle strobes. While that state is armed, and the endpoint is not isochronous, every IN token, every PING token and the end of every OUT data phase is answered with STALL. The OUT token alone draws no handshake.

Each STALL sets a sticky stall-sent flag and produces a one-cycle interrupt pulse. Firmware then clears the flag with its own strobe. The block also keeps the endpoint's data toggle. The toggle advances on successful data transfers that were not stalled. On an OUT endpoint, firmware can return it to DATA0 once a STALL has gone out.

There is no data stream at this block's edge: every pin is a control or status level or a one-cycle strobe. No valid/ready handshake applies, and nothing is ever held back.

Top module: `usb_ep_stall_ctrl`

## Requirements
- R1: After reset `hs_valid`, `stall_sent` and `irq` are 0, the data toggle is 0 (DATA0) and force-stall is disarmed.
- R2: With force-stall armed on a non-isochronous endpoint, an `tok_in` strobe in cycle t gives `hs_valid`=1 with `hs_sel`=2'b11 (STALL) in cycle t+1.
- R3: With force-stall armed, an OUT transaction is stalled only at the end of its data phase: `out_done` in cycle t gives STALL in cycle t+1, and no cycle without an event strobe shows `hs_valid`.
- R4: With force-stall armed, a `tok_ping` strobe in cycle t gives STALL in cycle t+1.
- R5: While stall is not in effect, an event in cycle t gives `hs_valid`=1 in cycle t+1 with `hs_sel`=2'b01 (ACK) when `norm_nak` was 0, and 2'b10 (NAK) when it was 1. `hs_valid` lasts one cycle per event.
- R6: `stall_sent` becomes 1 in the cycle a STALL is presented and stays 1 until a `fw_clr_sent` strobe. A clear strobe arriving in the same cycle as a stalled event leaves the flag at 1.
- R7: `irq` pulses high for exactly the cycle in which each STALL is presented.
- R8: Force-stall changes only on `fw_set_stall` and `fw_clr_stall`. Each takes effect for events from the next cycle on, and set wins when both arrive together.
- R9: When `ep_type` is 2'b01 (isochronous), force-stall is ignored. Events get the normal response of R5, and `stall_sent` does not change.
- R10: While stall is not in effect, the toggle inverts one cycle after `out_done` with `rx_good`=1, or after `tx_ack`. Data on a stalled OUT transaction is discarded and leaves the toggle unchanged.
- R11: `fw_tog_rst` sets the toggle to 0 in the next cycle only when `ep_dir_out`=1 and `stall_sent` is 1. Otherwise it is ignored. It takes priority over an inversion in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ep_type | input | 2 | Endpoint type: 00 control, 01 isochronous, 10 bulk, 11 interrupt |
| ep_dir_out | input | 1 | 1 for an OUT endpoint |
| tok_in | input | 1 | IN token received (strobe) |
| tok_ping | input | 1 | PING token received (strobe) |
| out_done | input | 1 | OUT data phase complete (strobe) |
| rx_good | input | 1 | OUT data was received without error, qualifies `out_done` |
| tx_ack | input | 1 | Host acknowledged IN data (strobe) |
| norm_nak | input | 1 | Normal decision of the protocol engine: 1 NAK, 0 ACK |
| fw_set_stall | input | 1 | Firmware arms force-stall (strobe) |
| fw_clr_stall | input | 1 | Firmware disarms force-stall (strobe) |
| fw_clr_sent | input | 1 | Firmware clears the stall-sent flag (strobe) |
| fw_tog_rst | input | 1 | Firmware toggle-reset command (strobe) |
| hs_valid | output | 1 | A handshake choice is presented this cycle |
| hs_sel | output | 2 | Handshake: 01 ACK, 10 NAK, 11 STALL, 00 none |
| stall_sent | output | 1 | Sticky stall-sent flag |
| irq | output | 1 | One-cycle interrupt per STALL |
| data_tog | output | 1 | Current data toggle, 0 = DATA0 |

## Verification
Every result is due exactly one cycle after the strobe that causes it. The handshake, the stall-sent flag, the interrupt pulse and the toggle are each one register away from the inputs. A firmware strobe therefore governs events from the following cycle on. The bench drives inputs on the falling edge. A reference model advances on the rising edge from the same inputs, and every output is compared with it on the next falling edge, so the one-cycle latency is checked on every clock. Directed checks then confirm the same-cycle collisions (clear against set, toggle-reset against inversion) at the cycle right after the collision.

// File: rtl/usbst_pkg.sv
package usbst_pkg;
  typedef enum logic [1:0] {
    HS_NONE  = 2'b00,
    HS_ACK   = 2'b01,
    HS_NAK   = 2'b10,
    HS_STALL = 2'b11
  } hs_e;

  localparam int unsigned TYPE_W = 2;
  localparam logic [TYPE_W-1:0] EPT_CTRL = 2'b00;
  localparam logic [TYPE_W-1:0] EPT_ISO  = 2'b01;
  localparam logic [TYPE_W-1:0] EPT_BULK = 2'b10;
  localparam logic [TYPE_W-1:0] EPT_INTR = 2'b11;
endpackage

// File: rtl/usbst_force.sv
module usbst_force
  import usbst_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fw_set,
  input  logic              fw_clr,
  input  logic [TYPE_W-1:0] ep_type,
  output logic              stall_eff
);
  logic force_q;

  // set has priority over clear when both strobes coincide
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      force_q <= 1'b0;
    else if (fw_set) force_q <= 1'b1;
    else if (fw_clr) force_q <= 1'b0;
  end

  // isochronous endpoints never stall
  assign stall_eff = force_q && (ep_type != EPT_ISO);

  AST_FORCE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!fw_set && !fw_clr) |=> $stable(force_q)); // R8
endmodule

// File: rtl/usbst_hs.sv
module usbst_hs
  import usbst_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tok_in,
  input  logic       tok_ping,
  input  logic       out_done,
  input  logic       norm_nak,
  input  logic       stall_eff,
  input  logic       fw_clr_sent,
  output logic       hs_valid,
  output logic [1:0] hs_sel,
  output logic       stall_sent,
  output logic       irq
);
  logic event_now;
  logic stall_now;
  hs_e  hs_next;

  assign event_now = tok_in || tok_ping || out_done;
  assign stall_now = event_now && stall_eff;

  always_comb begin
    if (!event_now)     hs_next = HS_NONE;
    else if (stall_eff) hs_next = HS_STALL;
    else if (norm_nak)  hs_next = HS_NAK;
    else                hs_next = HS_ACK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_valid <= 1'b0;
      hs_sel   <= HS_NONE;
      irq      <= 1'b0;
    end else begin
      hs_valid <= event_now;
      hs_sel   <= hs_next;
      irq      <= stall_now;
    end
  end

  // hardware set wins over a coincident firmware clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           stall_sent <= 1'b0;
    else if (stall_now)   stall_sent <= 1'b1;
    else if (fw_clr_sent) stall_sent <= 1'b0;
  end

  AST_HS_CODED:   assert property (@(posedge clk) disable iff (!rst_n)
    hs_valid |-> (hs_sel != HS_NONE)); // R5
  AST_SENT_HOLD:  assert property (@(posedge clk) disable iff (!rst_n)
    (stall_sent && !fw_clr_sent) |=> stall_sent); // R6
  AST_IRQ_MATCH:  assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (hs_valid && hs_sel == HS_STALL && stall_sent)); // R7
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    (!tok_in && !tok_ping && !out_done) |=> !hs_valid); // R3
endmodule

// File: rtl/usbst_toggle.sv
module usbst_toggle (
  input  logic clk,
  input  logic rst_n,
  input  logic out_done,
  input  logic rx_good,
  input  logic tx_ack,
  input  logic stall_eff,
  input  logic ep_dir_out,
  input  logic stall_sent,
  input  logic fw_tog_rst,
  output logic toggle
);
  logic rst_ok;
  logic flip;

  assign rst_ok = fw_tog_rst && ep_dir_out && stall_sent;
  assign flip   = !stall_eff && ((out_done && rx_good) || tx_ack);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      toggle <= 1'b0;
    else if (rst_ok) toggle <= 1'b0;
    else if (flip)   toggle <= ~toggle;
  end

  AST_TOG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_eff && !fw_tog_rst) |=> $stable(toggle)); // R10
  AST_TOG_RESET:  assert property (@(posedge clk) disable iff (!rst_n)
    (fw_tog_rst && ep_dir_out && stall_sent) |=> !toggle); // R11
endmodule

// File: rtl/usb_ep_stall_ctrl.sv
module usb_ep_stall_ctrl
  import usbst_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] ep_type,
  input  logic       ep_dir_out,
  input  logic       tok_in,
  input  logic       tok_ping,
  input  logic       out_done,
  input  logic       rx_good,
  input  logic       tx_ack,
  input  logic       norm_nak,
  input  logic       fw_set_stall,
  input  logic       fw_clr_stall,
  input  logic       fw_clr_sent,
  input  logic       fw_tog_rst,
  output logic       hs_valid,
  output logic [1:0] hs_sel,
  output logic       stall_sent,
  output logic       irq,
  output logic       data_tog
);
  logic stall_eff;

  usbst_force u_force (
    .clk(clk), .rst_n(rst_n), .fw_set(fw_set_stall), .fw_clr(fw_clr_stall),
    .ep_type(ep_type), .stall_eff(stall_eff)
  );

  usbst_hs u_hs (
    .clk(clk), .rst_n(rst_n), .tok_in(tok_in), .tok_ping(tok_ping),
    .out_done(out_done), .norm_nak(norm_nak), .stall_eff(stall_eff),
    .fw_clr_sent(fw_clr_sent), .hs_valid(hs_valid), .hs_sel(hs_sel),
    .stall_sent(stall_sent), .irq(irq)
  );

  usbst_toggle u_tog (
    .clk(clk), .rst_n(rst_n), .out_done(out_done), .rx_good(rx_good),
    .tx_ack(tx_ack), .stall_eff(stall_eff), .ep_dir_out(ep_dir_out),
    .stall_sent(stall_sent), .fw_tog_rst(fw_tog_rst), .toggle(data_tog)
  );

  AST_ISO_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (ep_type == EPT_ISO) |=> (hs_sel != HS_STALL)); // R9
endmodule

// File: tb/usb_ep_stall_ctrl_bench.sv
module usb_ep_stall_ctrl_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] ep_type = 2'b10;
  logic ep_dir_out = 1'b1;
  logic tok_in = 0, tok_ping = 0, out_done = 0, rx_good = 0, tx_ack = 0, norm_nak = 0;
  logic fw_set_stall = 0, fw_clr_stall = 0, fw_clr_sent = 0, fw_tog_rst = 0;
  logic hs_valid, stall_sent, irq, data_tog;
  logic [1:0] hs_sel;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit started = 0;
  bit done = 0;

  // reference model state
  bit m_force = 0, m_sent = 0, m_irq = 0, m_hv = 0, m_tog = 0;
  logic [1:0] m_hs = 2'b00;

  usb_ep_stall_ctrl u_usb_ep_stall_ctrl (
    .clk(clk), .rst_n(rst_n), .ep_type(ep_type), .ep_dir_out(ep_dir_out),
    .tok_in(tok_in), .tok_ping(tok_ping), .out_done(out_done), .rx_good(rx_good),
    .tx_ack(tx_ack), .norm_nak(norm_nak), .fw_set_stall(fw_set_stall),
    .fw_clr_stall(fw_clr_stall), .fw_clr_sent(fw_clr_sent), .fw_tog_rst(fw_tog_rst),
    .hs_valid(hs_valid), .hs_sel(hs_sel), .stall_sent(stall_sent), .irq(irq),
    .data_tog(data_tog)
  );

  always #2 clk = ~clk;

  always @(posedge clk) begin
    bit eff, ev;
    started <= 1'b1;
    cycles  <= cycles + 1;
    if (!rst_n) begin
      m_force <= 0; m_sent <= 0; m_irq <= 0; m_hv <= 0; m_hs <= 2'b00; m_tog <= 0;
    end else begin
      eff = m_force && (ep_type != 2'b01);
      ev  = tok_in || tok_ping || out_done;
      m_hv  <= ev;
      m_hs  <= !ev ? 2'b00 : eff ? 2'b11 : norm_nak ? 2'b10 : 2'b01;
      m_irq <= ev && eff;
      if (ev && eff) m_sent <= 1;
      else if (fw_clr_sent) m_sent <= 0;
      if (fw_set_stall) m_force <= 1;
      else if (fw_clr_stall) m_force <= 0;
      if (fw_tog_rst && ep_dir_out && m_sent) m_tog <= 0;
      else if (!eff && ((out_done && rx_good) || tx_ack)) m_tog <= ~m_tog;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // per-cycle comparison against the model, away from the rising edge
  always @(negedge clk) begin
    if (started && !done) begin
      chk("R5", "hs_valid", int'(hs_valid), int'(m_hv));
      chk("R2", "hs_sel", int'(hs_sel), int'(m_hs));
      chk("R6", "stall_sent", int'(stall_sent), int'(m_sent));
      chk("R7", "irq", int'(irq), int'(m_irq));
      chk("R10", "data_tog", int'(data_tog), int'(m_tog));
    end
  end

  task automatic tick();
    @(negedge clk);
    #0.5;
    tok_in = 0; tok_ping = 0; out_done = 0; tx_ack = 0;
    fw_set_stall = 0; fw_clr_stall = 0; fw_clr_sent = 0; fw_tog_rst = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=0", cycles);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    repeat (3) tick();
    // R1: reset state
    chk("R1", "hs_valid", int'(hs_valid), 0);
    chk("R1", "stall_sent", int'(stall_sent), 0);
    chk("R1", "data_tog", int'(data_tog), 0);
    rst_n = 1; tick();
    // R5: normal ACK, then NAK
    tok_in = 1; tick();
    chk("R5", "ack", int'(hs_sel), 1);
    norm_nak = 1; tok_ping = 1; tick();
    chk("R5", "nak", int'(hs_sel), 2);
    norm_nak = 0; tick();
    chk("R5", "valid drops", int'(hs_valid), 0);
    // R10: toggle advances on good OUT data and on tx_ack
    out_done = 1; rx_good = 1; tick();
    chk("R10", "tog after rx", int'(data_tog), 1);
    tx_ack = 1; tick();
    chk("R10", "tog after ack", int'(data_tog), 0);
    out_done = 1; tick();                  // toggle = 1
    // R11: toggle reset ignored while stall_sent is 0
    fw_tog_rst = 1; tick();
    chk("R11", "reset ignored", int'(data_tog), 1);
    // R8: set and clear together -> armed
    fw_set_stall = 1; fw_clr_stall = 1; tick();
    // R2: IN stalled
    tok_in = 1; tick();
    chk("R2", "in stall", int'(hs_sel), 3);
    chk("R7", "irq", int'(irq), 1);
    chk("R8", "set wins", int'(stall_sent), 1);
    tick();
    chk("R7", "irq pulse ends", int'(irq), 0);
    // R6: clear coinciding with PING stall -> stays set (R4)
    fw_clr_sent = 1; tok_ping = 1; tick();
    chk("R4", "ping stall", int'(hs_sel), 3);
    chk("R6", "set beats clear", int'(stall_sent), 1);
    fw_clr_sent = 1; tick();
    chk("R6", "cleared", int'(stall_sent), 0);
    // R3 and R10: stalled OUT data phase, toggle untouched
    out_done = 1; rx_good = 1; tick();
    chk("R3", "out stall", int'(hs_sel), 3);
    chk("R10", "tog frozen", int'(data_tog), 1);
    // R11: reset ignored on IN endpoint, then accepted on OUT endpoint
    ep_dir_out = 0; fw_tog_rst = 1; tick();
    chk("R11", "in ep ignored", int'(data_tog), 1);
    ep_dir_out = 1; fw_tog_rst = 1; tick();
    chk("R11", "reset to DATA0", int'(data_tog), 0);
    // R9: isochronous ignores force-stall
    ep_type = 2'b01; tok_in = 1; tick();
    chk("R9", "iso normal", int'(hs_sel), 1);
    fw_clr_sent = 1; tick();
    ep_type = 2'b01; out_done = 1; tick();
    chk("R9", "iso no flag", int'(stall_sent), 0);
    // R8: disarm -> normal again
    ep_type = 2'b00; fw_clr_stall = 1; tick();
    tok_in = 1; tick();
    chk("R8", "disarmed", int'(hs_sel), 1);
    // mixed pattern, model comparison each cycle
    lfsr = 16'hACE1;
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      ep_type = (lfsr[3:0] == 0) ? 2'b01 : 2'b10;
      ep_dir_out = lfsr[4] | lfsr[9];
      tok_in = lfsr[5] & lfsr[6];
      tok_ping = lfsr[7] & lfsr[8] & lfsr[2];
      out_done = lfsr[10] & lfsr[11];
      rx_good = lfsr[12];
      tx_ack = lfsr[13] & lfsr[14];
      norm_nak = lfsr[15];
      fw_set_stall = (lfsr[5:1] == 5'd3);
      fw_clr_stall = (lfsr[6:2] == 5'd9);
      fw_clr_sent = (lfsr[9:7] == 3'd5);
      fw_tog_rst = (lfsr[12:10] == 3'd2);
      tick();
    end
    tick();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule